// File: doc/BRIEF.md
# Unlock Sequence Decoder with Software Write Protection

This block sits beside the page buffer controller of a byte-wide nonvolatile memory. It watches every bus write cycle (address, data). It recognises a small set of unlock command sequences. These are a three-write form and a six-write form, and they share a single recogniser. Both forms open with AAh at 5555h followed by 55h at 2AAAh, and only address bits 14..0 take part in the compare.

The block holds one global protection flag that covers the whole array. From that flag and the recogniser it tells the page buffer controller, cycle by cycle, whether the current write may be taken as a byte load. Running the protected-write sequence has two effects: it turns protection on, and it opens exactly one page-load window. That window lasts until the page buffer controller reports that loading has ended. If a plain data write reaches the block while protection is on, the block discards it and stays unresponsive for a programmable number of cycles.

In identification mode, reads of the two lowest locations return fixed codes instead of array data.

Top module: `sdp_cmd_decoder`

## Requirements
- R1: After reset, protection is off, identification mode is off, `busy` is low, and no write has been accepted as a load.
- R2: While protection is off and no window is open, a write that is not the next expected step of a sequence is accepted as a load (`load_ok` high in the same cycle). A write that does match the next step is consumed and not accepted as a load.
- R3: The command byte A0h in the third step sets `prot_on` from the next cycle and opens a page-load window. Every write in the window is accepted as a load and bypasses the recogniser. A `load_done` pulse closes the window, and protection stays on afterwards.
- R4: While protection is on and no window is open, a write that is not the next expected step is discarded. `busy` then stays high for LOCK_CYCLES cycles. Every write during `busy` is ignored: no load, no sequence progress, no mode change.
- R5: The command byte 90h in the third step turns identification mode on. F0h in the third step turns it off.
- R6: In identification mode, a read with address bits 14..1 at zero returns BFh when bit 0 is 0 and DEV_ID when bit 0 is 1. Address bits above 14 play no part in this. Every other read, and every read outside identification mode, returns `arr_data` unchanged.
- R7: The six-write sequence (80h in the third step, then AAh/5555h, 55h/2AAAh, 20h/5555h) turns protection off from the next cycle.
- R8: The six-write sequence ending in 10h/5555h raises `erase_start` for exactly the cycle of that final write. It leaves the protection flag unchanged.
- R9: The six-write sequence ending in 60h/5555h turns identification mode on.
- R10: Address bits above bit 14 are ignored when sequence steps are matched.
- R11: A write that breaks a sequence returns the recogniser to its start, so the steps that follow it do not complete the broken sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write cycle strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| load_done | input | 1 | Page buffer controller reports end of page loading |
| rd_addr | input | ADDR_W | Read address |
| arr_data | input | 8 | Data read from the array |
| load_ok | output | 1 | Current write may be stored as a byte load |
| erase_start | output | 1 | Start full-array erase (one cycle) |
| prot_on | output | 1 | Global protection flag |
| id_mode | output | 1 | Identification mode active |
| busy | output | 1 | Lockout after a rejected protected write |
| rd_data | output | 8 | Read data after the identification multiplexer |

## Verification
The bench builds the block with LOCK_CYCLES=8 and DEV_ID=5Ah. The short lockout lets a rejected write, a whole sequence sent inside the lockout, and the expiry all fit in a few dozen cycles. The non-default device code shows that the parameter, and not a constant, reaches the read path. ADDR_W stays at 17, so the bench can drive addresses with bits 15 and 16 set into both the step matcher and the identification decode.

// File: rtl/sdp_cmd_decoder.sv
module sdp_cmd_decoder #(
  parameter int ADDR_W = 17,
  parameter logic [7:0] DEV_ID = 8'h07,
  parameter int LOCK_CYCLES = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              load_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_data,
  output logic              load_ok,
  output logic              erase_start,
  output logic              prot_on,
  output logic              id_mode,
  output logic              busy,
  output logic [7:0]        rd_data
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);

  typedef enum logic [2:0] {ST_IDLE, ST_U1, ST_U2, ST_X0, ST_X1, ST_X2} st_t;

  st_t state, nxt;
  logic window, hit, take;
  logic [CW-1:0] cnt;

  wire at_a = wr_addr[14:0] == 15'h5555;
  wire at_b = wr_addr[14:0] == 15'h2AAA;

  assign busy = cnt != '0;
  assign take = wr_en && !busy && !window;

  always_comb begin
    hit = 1'b0;
    nxt = ST_IDLE;
    case (state)
      ST_IDLE: begin hit = at_a && wr_data == 8'hAA; nxt = ST_U1; end
      ST_X0:   begin hit = at_a && wr_data == 8'hAA; nxt = ST_X1; end
      ST_U1:   begin hit = at_b && wr_data == 8'h55; nxt = ST_U2; end
      ST_X1:   begin hit = at_b && wr_data == 8'h55; nxt = ST_X2; end
      ST_U2: begin
        hit = at_a && (wr_data == 8'hA0 || wr_data == 8'h90 ||
                       wr_data == 8'hF0 || wr_data == 8'h80);
        nxt = (wr_data == 8'h80) ? ST_X0 : ST_IDLE;
      end
      ST_X2:   hit = at_a && (wr_data == 8'h20 || wr_data == 8'h10 || wr_data == 8'h60);
      default: ;
    endcase
  end

  assign load_ok = wr_en && !busy && (window || (!prot_on && !hit));
  assign erase_start = take && hit && state == ST_X2 && wr_data == 8'h10;

  assign rd_data = (id_mode && rd_addr[14:1] == '0) ?
                   (rd_addr[0] ? DEV_ID : 8'hBF) : arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      prot_on <= 1'b0;
      id_mode <= 1'b0;
      window  <= 1'b0;
      cnt     <= '0;
    end else begin
      if (busy) cnt <= cnt - 1'b1;
      else if (take && !hit && prot_on) cnt <= CW'(LOCK_CYCLES);
      if (load_done) window <= 1'b0;
      if (take) begin
        state <= hit ? nxt : ST_IDLE;
        if (hit && state == ST_U2) begin
          if (wr_data == 8'hA0) begin prot_on <= 1'b1; window <= 1'b1; end
          if (wr_data == 8'h90) id_mode <= 1'b1;
          if (wr_data == 8'hF0) id_mode <= 1'b0;
        end
        if (hit && state == ST_X2) begin
          if (wr_data == 8'h20) prot_on <= 1'b0;
          if (wr_data == 8'h60) id_mode <= 1'b1;
        end
      end
    end
  end

  a_r3_window_protected: assert property (@(posedge clk) disable iff (!rst_n)
    window |-> prot_on);
  a_r4_no_load_in_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_ok);
  a_r4_lockout_needs_prot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(prot_on));
  a_r2_load_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> wr_en);
  a_r5_id_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(id_mode) |-> $past(wr_en));
  a_r7_prot_moves_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_on) |-> $past(wr_en));
  a_r8_erase_single: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !busy && wr_en);
endmodule

// File: tb/test_sdp_cmd_decoder.sv
module test_sdp_cmd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 17;
  localparam int LOCK = 8;
  localparam logic [7:0] DID = 8'h5A;

  logic clk = 0, rst_n = 0, wr_en = 0, load_done = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, arr_data = 8'h3C;
  logic load_ok, erase_start, prot_on, id_mode, busy;
  logic [7:0] rd_data;
  int checks = 0, failures = 0;

  sdp_cmd_decoder #(.ADDR_W(AW), .DEV_ID(DID), .LOCK_CYCLES(LOCK)) i_sdp_cmd_decoder (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .load_done, .rd_addr, .arr_data,
    .load_ok, .erase_start, .prot_on, .id_mode, .busy, .rd_data);

  always #(CLK_PERIOD/2) clk = ~clk;

  int m_step = 0, m_cnt = 0;
  bit m_prot = 0, m_id = 0, m_win = 0;

  function automatic bit m_hit(logic [AW-1:0] a, logic [7:0] d);
    logic [14:0] x = a[14:0];
    case (m_step)
      0, 3: return x == 15'h5555 && d == 8'hAA;
      1, 4: return x == 15'h2AAA && d == 8'h55;
      2: return x == 15'h5555 && (d == 8'hA0 || d == 8'h90 || d == 8'hF0 || d == 8'h80);
      5: return x == 15'h5555 && (d == 8'h20 || d == 8'h10 || d == 8'h60);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) if (rst_n) begin
    bit h, tk;
    h  = m_hit(wr_addr, wr_data);
    tk = wr_en && m_cnt == 0 && !m_win;
    if (m_cnt > 0) m_cnt--;
    else if (tk && !h && m_prot) m_cnt = LOCK;
    if (load_done) m_win = 0;
    if (tk) begin
      if (!h) m_step = 0;
      else begin
        if (m_step == 2) begin
          if (wr_data == 8'hA0) begin m_prot = 1; m_win = 1; end
          if (wr_data == 8'h90) m_id = 1;
          if (wr_data == 8'hF0) m_id = 0;
        end
        if (m_step == 5) begin
          if (wr_data == 8'h20) m_prot = 0;
          if (wr_data == 8'h60) m_id = 1;
        end
        m_step = (m_step == 2) ? (wr_data == 8'h80 ? 3 : 0) :
                 (m_step == 5) ? 0 : m_step + 1;
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(bit we, logic [AW-1:0] a, logic [7:0] d, bit done, logic [AW-1:0] ra);
    bit h, eload, eerase;
    logic [7:0] erd;
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; load_done = done; rd_addr = ra;
    #1;
    h = m_hit(a, d);
    eload  = we && m_cnt == 0 && (m_win || (!m_prot && !h));
    eerase = we && m_cnt == 0 && !m_win && h && m_step == 5 && d == 8'h10;
    erd = (m_id && ra[14:1] == 0) ? (ra[0] ? DID : 8'hBF) : arr_data;
    check(load_ok == eload, "R2 load_ok", load_ok, eload);
    check(erase_start == eerase, "R8 erase_start", erase_start, eerase);
    check(prot_on == m_prot, "R3 prot_on", prot_on, m_prot);
    check(id_mode == m_id, "R5 id_mode", id_mode, m_id);
    check(busy == (m_cnt != 0), "R4 busy", busy, m_cnt != 0);
    check(rd_data == erd, "R6 rd_data", rd_data, erd);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [7:0] d); cyc(1, a, d, 0, '0); endtask
  task automatic idle(int n); for (int i = 0; i < n; i++) cyc(0, '0, 8'h00, 0, '0); endtask
  task automatic seq3(logic [7:0] c, logic [AW-1:0] hi = '0);
    wr(hi | 17'h05555, 8'hAA); wr(hi | 17'h02AAA, 8'h55); wr(hi | 17'h05555, c);
  endtask
  task automatic seq6(logic [7:0] c);
    seq3(8'h80); wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, c);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    check(!prot_on && !id_mode && !busy && !load_ok, "R1 reset", {prot_on, id_mode, busy, load_ok}, 0);
    idle(2);
    wr(17'h00100, 8'h12);                       // R2 plain load while unprotected
    // R11 broken sequence
    wr(17'h05555, 8'hAA); wr(17'h01234, 8'h00); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
    idle(1);
    check(prot_on == 0, "R11 broken seq no protect", prot_on, 0);
    // R5 / R6 identification
    seq3(8'h90); idle(1);
    for (int i = 0; i < 4; i++) cyc(0, '0, 0, 0, AW'(i));
    cyc(0, '0, 0, 0, 17'h18001);
    check(rd_data == DID, "R6 device code", rd_data, DID);
    cyc(0, '0, 0, 0, 17'h10000);
    check(rd_data == 8'hBF, "R6 maker code", rd_data, 8'hBF);
    seq3(8'hF0); idle(1);
    cyc(0, '0, 0, 0, 17'h00001);
    // R9 alternate entry
    seq6(8'h60); idle(1);
    check(id_mode == 1, "R9 alt id entry", id_mode, 1);
    seq3(8'hF0); idle(1);
    // R10 upper address bits ignored; R3 window
    seq3(8'hA0, 17'h18000); idle(1);
    check(prot_on == 1, "R10 high bits ignored", prot_on, 1);
    wr(17'h00200, 8'h01); wr(17'h05555, 8'hAA); wr(17'h00202, 8'h03);
    cyc(0, '0, 0, 1, '0); idle(1);
    check(prot_on == 1, "R3 stays protected", prot_on, 1);
    // R4 rejected write and lockout
    wr(17'h00300, 8'h77);
    seq3(8'h90); idle(LOCK);
    check(id_mode == 0 && busy == 0, "R4 lockout ignored seq", {id_mode, busy}, 0);
    // R8 erase keeps protection
    seq6(8'h10); idle(1);
    check(prot_on == 1, "R8 prot unchanged", prot_on, 1);
    // R7 disable
    seq6(8'h20); idle(1);
    check(prot_on == 0, "R7 protection off", prot_on, 0);
    wr(17'h00400, 8'h44);
    idle(3);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule